// File: doc/BRIEF.md
# Indirect Gate Schedule Access Port

This block lets software reach a time-aware gate schedule's storage through only two bus registers. The storage is a small file of six configuration words and a large gate list. Software loads a 32-bit value into the data register. It then writes the control register with a target address, a target select, a direction and a start bit. The block carries out the access over a fixed number of cycles and clears the start bit when it is done. Software polls that bit before it touches either register again.

A write moves the data register into the addressed word. A read loads the addressed word into the data register before the start bit drops. An address outside the selected target sets an error flag and changes no storage.

The configuration words drive the scheduler directly as wide outputs. The gate list has a separate synchronous read port for the scheduler.

The sequencer has five states:
- **IDLE** goes to **DECODE** when a control write sets the start bit.
- **DECODE** checks the range and always goes to **ACCESS**.
- **ACCESS** performs the read or write, unless the error flag is set, and goes to **SETTLE**.
- **SETTLE** waits `SETTLE_CYC` cycles and then goes to **FINISH**.
- **FINISH** clears the start bit and returns to **IDLE**.

Top module: `gla_port`

## Requirements
- R1: After reset the control word, the data register and all six configuration words read as zero, and the sequencer is idle.
- R2: Byte offset 0x0 is the control register and offset 0x4 is the data register. Reads return their current contents. Any other offset reads as zero, and writes to it have no effect.
- R3: The control word has start at bit 0, direction at bit 1 (1 = read, 0 = write), target select at bit 2 (1 = configuration words, 0 = gate list), error at bit 3 (read-only), and a 12-bit address at bits 19:8. A control write while idle loads the address, direction and select fields and clears the error flag. If the start bit is 0 in that write, no access takes place.
- R4: Setting the start bit launches one access through DECODE, ACCESS, SETTLE and FINISH. The start bit then reads 0 and the sequencer is idle again.
- R5: The start bit reads 1 for exactly 3 + `SETTLE_CYC` clock cycles after the clock edge that accepts the control write, which is 5 cycles by default.
- R6: While the start bit is set, bus writes to the control and data registers are ignored.
- R7: A read access loads the addressed word into the data register before the start bit clears.
- R8: Configuration index 0 is the base time low word and 1 is the base time high word. Index 2 is the cycle time low word and 3 is the cycle time high word. Index 4 is the time extension and 5 is the list length. A write access updates the matching output: `base_time` = {index 1, index 0}, `cycle_time` = {index 3, index 2}.
- R9: A gate list write stores the data register at the addressed entry, for entries 0 to 1023. The scheduler port returns the entry at `sched_idx` one clock after it is presented.
- R10: A configuration address of 6 or more, or a gate list address of 1024 or more, sets the error flag. In that case no storage is written and a read leaves the data register unchanged. The next control write clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 4 | Byte offset of the bus access |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data for `reg_addr`, combinational |
| base_time | output | 64 | Configuration indices 1 and 0 |
| cycle_time | output | 64 | Configuration indices 3 and 2 |
| time_ext | output | 32 | Configuration index 4 |
| list_len | output | 32 | Configuration index 5 |
| sched_idx | input | 10 | Scheduler read index into the gate list |
| sched_entry | output | 32 | Gate list entry, registered |

## Verification
The assertions check the sequencer on every cycle:
- The start bit is high exactly while the sequencer is away from IDLE.
- FINISH always returns to idle with the start bit clear.
- The settle counter stays within its bound.
- The address, select and direction fields are frozen during an access.
- The data register changes only on the read step.
- A flagged access never raises a write enable.
- A gate list entry read back one cycle after a write shows the written word.

Only the bench's scenarios can show the rest:
- The exact number of busy cycles seen at the bus.
- The mapping of each configuration index to its output.
- That writes made during an access are really lost.
- That an out-of-range access leaves neighbouring words untouched.

// File: rtl/gla_pkg.sv
package gla_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACCESS,
        ST_SETTLE,
        ST_FINISH
    } gla_state_e;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_READ_BIT  = 1;
    localparam int CTRL_CFG_BIT   = 2;
    localparam int CTRL_ERR_BIT   = 3;
    localparam int CTRL_ADDR_LSB  = 8;

    localparam int CFG_COUNT = 6;
    localparam int CFG_IDX_W = 3;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_DATA = 4'h4;
endpackage

// File: rtl/gla_cfg_file.sv
module gla_cfg_file
    import gla_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [CFG_IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [CFG_COUNT-1:0][DATA_W-1:0] regs_o
);
    logic [CFG_COUNT-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < CFG_COUNT; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (we && (idx == CFG_IDX_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < CFG_COUNT; i++) begin
            if (idx == CFG_IDX_W'(i)) rdata = regs_q[i];
        end
    end

    assign regs_o = regs_q;

    AST_CFG_IDX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (idx < CFG_IDX_W'(CFG_COUNT)));  // R10
endmodule

// File: rtl/gla_list_mem.sv
module gla_list_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [AW-1:0]     b_addr,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end

    AST_LIST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a_we) && (b_addr == $past(a_addr)))
        |=> (b_rdata == $past(a_wdata, 2)));  // R9
endmodule

// File: rtl/gla_seq.sv
module gla_seq
    import gla_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int AF_W       = 12,
    parameter int GL_DEPTH   = 1024,
    parameter int GL_AW      = $clog2(GL_DEPTH),
    parameter int SETTLE_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [3:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 cfg_we,
    output logic [CFG_IDX_W-1:0] cfg_idx,
    output logic [DATA_W-1:0]    cfg_wdata,
    input  logic [DATA_W-1:0]    cfg_rdata,
    output logic                 gl_we,
    output logic [GL_AW-1:0]     gl_addr,
    output logic [DATA_W-1:0]    gl_wdata,
    input  logic [DATA_W-1:0]    gl_rdata
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    gla_state_e        state, state_n;
    logic              op_start, op_read, op_cfg, op_err;
    logic [AF_W-1:0]   op_addr;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  settle_cnt;
    logic              wr_ctrl, wr_data, launch, range_ok, do_write;
    logic [DATA_W-1:0] ctrl_word;
    logic              ctrl_unused;

    assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL) && !op_start;
    assign wr_data = reg_wr && (reg_addr == OFF_DATA) && !op_start;
    assign launch  = wr_ctrl && reg_wdata[CTRL_START_BIT];
    assign range_ok = op_cfg ? (op_addr < AF_W'(CFG_COUNT))
                             : (op_addr < AF_W'(GL_DEPTH));
    assign ctrl_unused = ^{reg_wdata[CTRL_ADDR_LSB-1:CTRL_ERR_BIT],
                           reg_wdata[DATA_W-1:CTRL_ADDR_LSB+AF_W]};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (launch) state_n = ST_DECODE;
            ST_DECODE: state_n = ST_ACCESS;
            ST_ACCESS: state_n = ST_SETTLE;
            ST_SETTLE: if (settle_cnt == CNT_W'(SETTLE_CYC - 1)) state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Registers driven by the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_start   <= 1'b0;
            op_read    <= 1'b0;
            op_cfg     <= 1'b0;
            op_err     <= 1'b0;
            op_addr    <= '0;
            data_q     <= '0;
            settle_cnt <= '0;
        end else begin
            if (wr_data) data_q <= reg_wdata;
            if (wr_ctrl) begin
                op_start <= reg_wdata[CTRL_START_BIT];
                op_read  <= reg_wdata[CTRL_READ_BIT];
                op_cfg   <= reg_wdata[CTRL_CFG_BIT];
                op_addr  <= reg_wdata[CTRL_ADDR_LSB +: AF_W];
                op_err   <= 1'b0;
            end
            if (state == ST_DECODE && !range_ok) op_err <= 1'b1;
            if (state == ST_ACCESS && op_read && !op_err)
                data_q <= op_cfg ? cfg_rdata : gl_rdata;
            if (state == ST_ACCESS)      settle_cnt <= '0;
            else if (state == ST_SETTLE) settle_cnt <= settle_cnt + 1'b1;
            if (state == ST_FINISH) op_start <= 1'b0;
        end
    end

    // Storage strobes and bus read mux
    assign do_write  = (state == ST_ACCESS) && !op_read && !op_err;
    assign cfg_we    = do_write && op_cfg;
    assign gl_we     = do_write && !op_cfg;
    assign cfg_idx   = op_addr[CFG_IDX_W-1:0];
    assign gl_addr   = op_addr[GL_AW-1:0];
    assign cfg_wdata = data_q;
    assign gl_wdata  = data_q;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_START_BIT] = op_start;
        ctrl_word[CTRL_READ_BIT]  = op_read;
        ctrl_word[CTRL_CFG_BIT]   = op_cfg;
        ctrl_word[CTRL_ERR_BIT]   = op_err;
        ctrl_word[CTRL_ADDR_LSB +: AF_W] = op_addr;
        unique case (reg_addr)
            OFF_CTRL: reg_rdata = ctrl_word;
            OFF_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_START_TRACKS_FSM: assert property (@(posedge clk) disable iff (!rst_n)
        op_start == (state != ST_IDLE));  // R4
    AST_FINISH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (!op_start && state == ST_IDLE));  // R4
    AST_SETTLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (settle_cnt < CNT_W'(SETTLE_CYC)));  // R5
    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && state != ST_FINISH)
        |=> ($stable(op_addr) && $stable(op_read) && $stable(op_cfg)));  // R6
    AST_DATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !(state == ST_ACCESS && op_read)) |=> $stable(data_q));  // R7
    AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> !(cfg_we || gl_we));  // R10
endmodule

// File: rtl/gla_port.sv
module gla_port
    import gla_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int GL_DEPTH   = 1024,
    parameter int AF_W       = 12,
    parameter int SETTLE_CYC = 2,
    localparam int GL_AW     = $clog2(GL_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [3:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [2*DATA_W-1:0] base_time,
    output logic [2*DATA_W-1:0] cycle_time,
    output logic [DATA_W-1:0]   time_ext,
    output logic [DATA_W-1:0]   list_len,
    input  logic [GL_AW-1:0]    sched_idx,
    output logic [DATA_W-1:0]   sched_entry
);
    logic                 cfg_we, gl_we;
    logic [CFG_IDX_W-1:0] cfg_idx;
    logic [DATA_W-1:0]    cfg_wdata, cfg_rdata, gl_wdata, gl_rdata;
    logic [GL_AW-1:0]     gl_addr;
    logic [CFG_COUNT-1:0][DATA_W-1:0] cfg_regs;

    gla_seq #(
        .DATA_W(DATA_W), .AF_W(AF_W), .GL_DEPTH(GL_DEPTH),
        .GL_AW(GL_AW), .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .gl_we(gl_we), .gl_addr(gl_addr), .gl_wdata(gl_wdata), .gl_rdata(gl_rdata)
    );

    gla_cfg_file #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .regs_o(cfg_regs)
    );

    gla_list_mem #(.DATA_W(DATA_W), .DEPTH(GL_DEPTH), .AW(GL_AW)) u_list (
        .clk(clk), .rst_n(rst_n), .a_we(gl_we), .a_addr(gl_addr), .a_wdata(gl_wdata),
        .a_rdata(gl_rdata), .b_addr(sched_idx), .b_rdata(sched_entry)
    );

    assign base_time  = {cfg_regs[1], cfg_regs[0]};
    assign cycle_time = {cfg_regs[3], cfg_regs[2]};
    assign time_ext   = cfg_regs[4];
    assign list_len   = cfg_regs[5];
endmodule

// File: tb/tb_gla_port.sv
module tb_gla_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] base_time, cycle_time;
    logic [31:0] time_ext, list_len;
    logic [9:0]  sched_idx = '0;
    logic [31:0] sched_entry;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    gla_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_time(base_time),
        .cycle_time(cycle_time), .time_ext(time_ext), .list_len(list_len),
        .sched_idx(sched_idx), .sched_entry(sched_entry)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit st, input bit rd, input bit cf, input int addr);
        return (32'(addr) << 8) | (32'(cf) << 2) | (32'(rd) << 1) | 32'(st);
    endfunction

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] c;
        n = 0;
        reg_read(4'h0, c);
        while (c[0] && n < 50) begin
            @(negedge clk);
            n++;
            reg_read(4'h0, c);
        end
    endtask

    task automatic do_op(input bit rd, input bit cf, input int addr, output int n);
        reg_write(4'h0, mk(1'b1, rd, cf, addr));
        wait_idle(n);
    endtask

    task automatic put(input bit cf, input int addr, input logic [31:0] v);
        int n;
        reg_write(4'h4, v);
        do_op(1'b0, cf, addr, n);
    endtask

    task automatic get(input bit cf, input int addr, output logic [31:0] v);
        int n;
        do_op(1'b1, cf, addr, n);
        reg_read(4'h4, v);
    endtask

    task automatic sched_rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        sched_idx = 10'(idx);
        @(negedge clk);
        v = sched_entry;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(4'h0, v); chk(v == 0, "R1 ctrl", v, 0);
        reg_read(4'h4, v); chk(v == 0, "R1 data", v, 0);
        chk(base_time == 0 && cycle_time == 0, "R1 times", base_time, 0);
        chk(time_ext == 0 && list_len == 0, "R1 ext/len", list_len, 0);
    endtask

    task automatic t_bus_map();
        logic [31:0] v;
        reg_write(4'h4, 32'hA5A5_0001);
        reg_write(4'h8, 32'hFFFF_FFFF);
        reg_read(4'h8, v); chk(v == 0, "R2 unmapped read", v, 0);
        reg_read(4'h4, v); chk(v == 32'hA5A5_0001, "R2 data kept", v, 32'hA5A5_0001);
        reg_read(4'h0, v); chk(v == 0, "R2 ctrl kept", v, 0);
    endtask

    task automatic t_cfg_write();
        put(1'b1, 0, 32'h89AB_CDEF);
        put(1'b1, 1, 32'h0123_4567);
        put(1'b1, 2, 32'h000F_4240);
        put(1'b1, 3, 32'h0000_0002);
        put(1'b1, 4, 32'h0000_0055);
        put(1'b1, 5, 32'h0000_0040);
        chk(base_time == 64'h0123_4567_89AB_CDEF, "R8 base_time", base_time, 64'h0123_4567_89AB_CDEF);
        chk(cycle_time == 64'h2_000F_4240, "R8 cycle_time", cycle_time, 64'h2_000F_4240);
        chk(time_ext == 32'h55, "R8 time_ext", time_ext, 32'h55);
        chk(list_len == 32'h40, "R8 list_len", list_len, 32'h40);
    endtask

    task automatic t_cfg_read();
        logic [31:0] v;
        get(1'b1, 3, v); chk(v == 32'h2, "R7 cfg read idx3", v, 32'h2);
        get(1'b1, 0, v); chk(v == 32'h89AB_CDEF, "R7 cfg read idx0", v, 32'h89AB_CDEF);
    endtask

    task automatic t_list();
        logic [31:0] v;
        put(1'b0, 0, 32'h0000_1111);
        put(1'b0, 517, 32'hCAFE_0517);
        put(1'b0, 1023, 32'hBEEF_03FF);
        get(1'b0, 517, v); chk(v == 32'hCAFE_0517, "R9 port read 517", v, 32'hCAFE_0517);
        get(1'b0, 1023, v); chk(v == 32'hBEEF_03FF, "R9 port read 1023", v, 32'hBEEF_03FF);
        sched_rd(0, v); chk(v == 32'h1111, "R9 sched read 0", v, 32'h1111);
        sched_rd(1023, v); chk(v == 32'hBEEF_03FF, "R9 sched read 1023", v, 32'hBEEF_03FF);
    endtask

    task automatic t_latency();
        int n;
        logic [31:0] c;
        reg_write(4'h4, 32'h0000_0777);
        do_op(1'b0, 1'b0, 12, n);
        chk(n == 5, "R5 busy cycles", 64'(n), 5);
        reg_read(4'h0, c);
        chk(c == mk(1'b0, 1'b0, 1'b0, 12), "R4 start cleared", c, mk(1'b0, 1'b0, 1'b0, 12));
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [31:0] v;
        reg_write(4'h4, 32'h0000_AAAA);
        reg_write(4'h0, mk(1'b1, 1'b0, 1'b0, 5));
        reg_write(4'h4, 32'h0000_BBBB);
        reg_write(4'h0, mk(1'b1, 1'b1, 1'b1, 2));
        wait_idle(n);
        reg_read(4'h4, v); chk(v == 32'hAAAA, "R6 data ignored", v, 32'hAAAA);
        reg_read(4'h0, v);
        chk(v == mk(1'b0, 1'b0, 1'b0, 5), "R6 ctrl ignored", v, mk(1'b0, 1'b0, 1'b0, 5));
        sched_rd(5, v); chk(v == 32'hAAAA, "R6 entry from first data", v, 32'hAAAA);
    endtask

    task automatic t_no_start();
        logic [31:0] v;
        int n;
        reg_write(4'h4, 32'h0000_9999);
        reg_write(4'h0, mk(1'b0, 1'b0, 1'b1, 5));
        repeat (8) @(negedge clk);
        reg_read(4'h0, v);
        chk(v == mk(1'b0, 1'b0, 1'b1, 5), "R3 fields loaded", v, mk(1'b0, 1'b0, 1'b1, 5));
        chk(list_len == 32'h40, "R3 no access without start", list_len, 32'h40);
        n = 0;
    endtask

    task automatic t_range();
        logic [31:0] v;
        put(1'b1, 6, 32'hDEAD_0006);
        reg_read(4'h0, v); chk(v[3] == 1'b1, "R10 cfg err flag", v, 32'h8);
        chk(list_len == 32'h40 && time_ext == 32'h55, "R10 cfg untouched", list_len, 32'h40);
        put(1'b0, 1024, 32'h0000_2222);
        reg_read(4'h0, v); chk(v[3] == 1'b1, "R10 list err flag", v, 32'h8);
        sched_rd(0, v); chk(v == 32'h1111, "R10 entry0 untouched", v, 32'h1111);
        reg_write(4'h4, 32'h0000_3333);
        get(1'b0, 4095, v); chk(v == 32'h3333, "R10 read keeps data", v, 32'h3333);
        reg_write(4'h0, mk(1'b0, 1'b0, 1'b0, 1));
        reg_read(4'h0, v); chk(v[3] == 1'b0, "R10 err cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus_map();
        t_cfg_write();
        t_cfg_read();
        t_list();
        t_latency();
        t_busy_ignore();
        t_no_start();
        t_range();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule